// File: doc/BRIEF.md
# GPIO interrupt sense controller

This block watches 32 general-purpose input pins and turns selected pin activity into interrupt requests. Every pin carries its own 4-bit trigger code. The code selects one of five detection modes: rising edge, falling edge, either edge, high level or low level. Eight codes are packed into each 32-bit sense register. The pins are asynchronous to the block clock, so they pass through a synchronizer first. Edges are found by comparing the synchronized value with its value one cycle earlier.

Each detected event sets a sticky raw pending bit. A per-pin allow register gates detection. An enable mask, set and cleared through separate write-one registers, combines with the allow bits to form the masked status vector. Software acknowledges a pending bit by writing a one to it. Two interrupt lines leave the block: one for the lower sixteen pins and one for the upper sixteen.

To change a pin's trigger safely, software uses this sequence: drop the pin's allow bit, rewrite its sense field, acknowledge any stale pending bit, then set the allow bit again.

Top module: `gpio_irq_sense`

## Requirements
- R1: Edge sense codes are 8 (rising), 9 (falling) and 12 (both edges). The field for pin n sits in the sense register at address 0x40 + 4*(n/8), in bits 4*(n%8)+3 down to 4*(n%8). Sense registers read back as written. A pin set to an edge code sets its raw pending bit once per matching transition, and never on the other transition.
- R2: Level sense codes are 10 (high) and 11 (low). While the pin holds the active level and is allowed, its raw pending bit is set every cycle. It therefore comes back on the cycle after an acknowledge.
- R3: The allow register at 0x14 is read/write, one bit per pin. A pin with allow bit 0 sets no pending bit. An edge that happened while the pin was disallowed is not reported once the pin is allowed.
- R4: Writing ones to 0x18 enables those pins' interrupts, and writing ones to 0x1C disables them. Other bits keep their state. Reading 0x18 returns the enable mask.
- R5: Reading 0x20 returns the raw pending bits. Reading 0x24 returns the raw pending bits ANDed with the allow bits and the enable mask.
- R6: Writing ones to 0x28 clears those raw pending bits. A new event on the same cycle wins over the clear.
- R7: irq_lo is the OR of masked status bits 15:0. irq_hi is the OR of masked status bits 31:16.
- R8: A sense field holding any code other than 8 to 12 never sets a pending bit.
- R9: After reset, all allow bits, enable bits, raw pending bits and sense fields are zero, and both interrupt outputs are low.
- R10: A pin change that is detected shows up as a raw pending bit after the third rising clock edge following the change, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pins_i | input | 32 | Asynchronous GPIO input levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| irq_lo_o | output | 1 | Interrupt for pins 15:0 |
| irq_hi_o | output | 1 | Interrupt for pins 31:16 |

## Verification
A corrupted edge-history flop shows up as a spurious or missing raw pending bit at 0x20. That happens on the third edge after the pin change, so the bench samples precisely there and one cycle earlier. Wrong sense decoding or wrong field placement sets bits for the wrong pin or on the wrong transition. The bench catches this by stepping each pin through both transitions and reading the raw vector after each one. A stuck enable, allow or pending bit is seen within one read of 0x24, or on irq_lo_o/irq_hi_o, in the same cycle the register changes. The set-beats-clear race shows up as a level pin whose pending bit survives its own acknowledge.

// File: rtl/gis_pkg.sv
package gis_pkg;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned ADDR_W  = 8;

  localparam logic [FIELD_W-1:0] SNS_RISE = 4'd8;
  localparam logic [FIELD_W-1:0] SNS_FALL = 4'd9;
  localparam logic [FIELD_W-1:0] SNS_HIGH = 4'd10;
  localparam logic [FIELD_W-1:0] SNS_LOW  = 4'd11;
  localparam logic [FIELD_W-1:0] SNS_BOTH = 4'd12;

  localparam logic [ADDR_W-1:0] ADR_ALLOW  = 8'h14;
  localparam logic [ADDR_W-1:0] ADR_UNMASK = 8'h18;
  localparam logic [ADDR_W-1:0] ADR_MASK   = 8'h1C;
  localparam logic [ADDR_W-1:0] ADR_RAW    = 8'h20;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 8'h24;
  localparam logic [ADDR_W-1:0] ADR_ACK    = 8'h28;
  localparam logic [ADDR_W-1:0] ADR_SENSE0 = 8'h40;
endpackage

// File: rtl/gis_sync.sv
module gis_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign chain_d[s] = d_i;
      end else begin : g_next
        assign chain_d[s] = chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gis_detect.sv
module gis_detect
  import gis_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPINS-1:0]         pin_s_i,
  input  logic [NPINS*FIELD_W-1:0] sense_i,
  input  logic [NPINS-1:0]         allow_i,
  output logic [NPINS-1:0]         evt_o
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] prev_d;
  logic             prev_en;

  always_comb begin
    prev_en = 1'b1;
    prev_d  = pin_s_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= '0;
    else if (prev_en) prev_q <= prev_d;
  end

  generate
    for (genvar n = 0; n < NPINS; n++) begin : g_pin
      logic [FIELD_W-1:0] code;
      logic               hit;
      assign code = sense_i[n*FIELD_W +: FIELD_W];
      always_comb begin
        case (code)
          SNS_RISE: hit = pin_s_i[n] & ~prev_q[n];
          SNS_FALL: hit = ~pin_s_i[n] & prev_q[n];
          SNS_BOTH: hit = pin_s_i[n] ^ prev_q[n];
          SNS_HIGH: hit = pin_s_i[n];
          SNS_LOW:  hit = ~pin_s_i[n];
          default:  hit = 1'b0;
        endcase
      end
      assign evt_o[n] = hit & allow_i[n];
    end
  endgenerate
endmodule

// File: rtl/gis_pending.sv
module gis_pending #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] evt_i,
  input  logic [NPINS-1:0] ack_i,
  output logic [NPINS-1:0] raw_o
);
  logic [NPINS-1:0] raw_q;
  logic [NPINS-1:0] raw_d;

  always_comb raw_d = (raw_q & ~ack_i) | evt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw_o = raw_q;

  // R6: an acknowledged bit with no new event is gone on the next cycle
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(ack_i) & ~$past(evt_i)) == '0));

  // R6: an event always lands, acknowledge or not
  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/gis_regs.sv
module gis_regs
  import gis_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NPINS-1:0]         wdata_i,
  input  logic [NPINS-1:0]         raw_i,
  input  logic [NPINS-1:0]         status_i,
  output logic [NPINS-1:0]         rdata_o,
  output logic [NPINS-1:0]         allow_o,
  output logic [NPINS-1:0]         unmask_o,
  output logic [NPINS*FIELD_W-1:0] sense_o,
  output logic [NPINS-1:0]         ack_o
);
  localparam int unsigned PER_REG = NPINS / FIELD_W;
  localparam int unsigned NSENSE  = NPINS / PER_REG;

  logic [NPINS-1:0] allow_q, allow_d;
  logic             allow_en;
  logic [NPINS-1:0] unmask_q, unmask_d;
  logic             unmask_en;
  logic [NSENSE-1:0][NPINS-1:0] sense_q;
  logic [NSENSE-1:0]            sense_en;

  always_comb begin
    allow_en  = wr_en_i && (addr_i == ADR_ALLOW);
    allow_d   = wdata_i;
    unmask_en = wr_en_i && ((addr_i == ADR_UNMASK) || (addr_i == ADR_MASK));
    unmask_d  = (addr_i == ADR_UNMASK) ? (unmask_q | wdata_i) : (unmask_q & ~wdata_i);
    ack_o     = (wr_en_i && (addr_i == ADR_ACK)) ? wdata_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allow_q  <= '0;
      unmask_q <= '0;
    end else begin
      if (allow_en)  allow_q  <= allow_d;
      if (unmask_en) unmask_q <= unmask_d;
    end
  end

  generate
    for (genvar k = 0; k < NSENSE; k++) begin : g_sense
      assign sense_en[k] = wr_en_i && (addr_i == ADR_SENSE0 + ADDR_W'(4*k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           sense_q[k] <= '0;
        else if (sense_en[k]) sense_q[k] <= wdata_i;
      end
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_ALLOW:  rdata_o = allow_q;
      ADR_UNMASK: rdata_o = unmask_q;
      ADR_RAW:    rdata_o = raw_i;
      ADR_STATUS: rdata_o = status_i;
      default: begin
        for (int k = 0; k < NSENSE; k++) begin
          if (addr_i == ADR_SENSE0 + ADDR_W'(4*k)) rdata_o = sense_q[k];
        end
      end
    endcase
  end

  assign allow_o  = allow_q;
  assign unmask_o = unmask_q;
  assign sense_o  = sense_q;

  // R4: write-one enable sets the named bits
  p_unmask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADR_UNMASK) |=> ((unmask_q & $past(wdata_i)) == $past(wdata_i)));

  // R4: write-one disable clears the named bits and leaves the rest
  p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADR_MASK) |=>
      (((unmask_q & $past(wdata_i)) == '0) &&
       ((unmask_q & ~$past(wdata_i)) == ($past(unmask_q) & ~$past(wdata_i)))));
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gis_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pins_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [NPINS-1:0]  reg_wdata_i,
  output logic [NPINS-1:0]  reg_rdata_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  localparam int unsigned HALF = NPINS / 2;

  logic [1:0]               rst_sync_q;
  logic                     rst_ni;
  logic [NPINS-1:0]         pin_s;
  logic [NPINS-1:0]         evt;
  logic [NPINS-1:0]         ack;
  logic [NPINS-1:0]         raw;
  logic [NPINS-1:0]         allow;
  logic [NPINS-1:0]         unmask;
  logic [NPINS-1:0]         status;
  logic [NPINS*FIELD_W-1:0] sense;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  gis_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ni), .d_i(pins_i), .q_o(pin_s));

  gis_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_ni), .pin_s_i(pin_s), .sense_i(sense),
    .allow_i(allow), .evt_o(evt));

  gis_pending #(.NPINS(NPINS)) u_pending (
    .clk(clk), .rst_n(rst_ni), .evt_i(evt), .ack_i(ack), .raw_o(raw));

  gis_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_ni), .wr_en_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .raw_i(raw), .status_i(status),
    .rdata_o(reg_rdata_o), .allow_o(allow), .unmask_o(unmask),
    .sense_o(sense), .ack_o(ack));

  assign status   = raw & allow & unmask;
  assign irq_lo_o = |status[HALF-1:0];
  assign irq_hi_o = |status[NPINS-1:HALF];

  // R3: a pending bit only rises on a pin that was allowed the cycle before
  p_no_set_disallowed_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ((raw & ~$past(raw) & ~$past(allow)) == '0));

  // R7: an interrupt line implies a pending raw bit in its half
  p_irq_has_source_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_lo_o |-> (raw[HALF-1:0] != '0)) and (irq_hi_o |-> (raw[NPINS-1:HALF] != '0)));
endmodule

// File: tb/gpio_irq_sense_tb.sv
module gpio_irq_sense_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_lo, irq_hi;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_sense dut_i (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_lo_o(irq_lo), .irq_hi_o(irq_hi));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pin(input int i, input logic v);
    @(negedge clk);
    pins[i] = v;
  endtask

  task automatic check_raw(input string req, input logic [31:0] exp);
    logic [31:0] v;
    rreg(8'h20, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rreg(8'h14, v); check("R9 allow", v, '0);
    rreg(8'h18, v); check("R9 enable", v, '0);
    rreg(8'h20, v); check("R9 raw", v, '0);
    rreg(8'h24, v); check("R9 status", v, '0);
    rreg(8'h44, v); check("R9 sense", v, '0);
    check("R9 irqs", {30'd0, irq_hi, irq_lo}, '0);
  endtask

  task automatic t_setup();
    logic [31:0] v;
    wreg(8'h40, 32'hF83BAC98);
    wreg(8'h48, 32'h0008_0000);
    wreg(8'h18, 32'hFFFF_FFFF);
    rreg(8'h40, v); check("R1 sense readback", v, 32'hF83BAC98);
    rreg(8'h48, v); check("R1 sense readback hi", v, 32'h0008_0000);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    wreg(8'h14, 32'h1);
    pin(0, 1'b1);
    cyc(2); check_raw("R10 not after 2 edges", 32'h0);
    cyc(1); check_raw("R10 after 3 edges", 32'h1);
    rreg(8'h24, v); check("R5 status", v, 32'h1);
    check("R7 lo only", {30'd0, irq_hi, irq_lo}, 32'h1);
    wreg(8'h28, 32'h1); cyc(4);
    check_raw("R6 edge cleared", 32'h0);
    pin(0, 1'b0); cyc(4);
    check_raw("R1 rise ignores fall", 32'h0);
  endtask

  task automatic t_fall();
    wreg(8'h14, 32'h2);
    pin(1, 1'b1); cyc(4); check_raw("R1 fall ignores rise", 32'h0);
    pin(1, 1'b0); cyc(4); check_raw("R1 fall detected", 32'h2);
    wreg(8'h28, 32'h2);
  endtask

  task automatic t_both();
    wreg(8'h14, 32'h4);
    pin(2, 1'b1); cyc(4); check_raw("R1 both rise", 32'h4);
    wreg(8'h28, 32'h4);
    pin(2, 1'b0); cyc(4); check_raw("R1 both fall", 32'h4);
    wreg(8'h28, 32'h4); cyc(2); check_raw("R1 both cleared", 32'h0);
  endtask

  task automatic t_level();
    wreg(8'h14, 32'h18);
    cyc(3); check_raw("R2 low level active", 32'h10);
    wreg(8'h28, 32'h10); cyc(1); check_raw("R2 R6 level re-sets", 32'h10);
    pin(4, 1'b1); cyc(4); wreg(8'h28, 32'h10); cyc(2);
    check_raw("R2 low level gone", 32'h0);
    pin(3, 1'b1); cyc(4); check_raw("R2 high level", 32'h08);
    wreg(8'h28, 32'h08); cyc(1); check_raw("R2 high re-sets", 32'h08);
    pin(3, 1'b0); cyc(4); wreg(8'h28, 32'h08); cyc(2);
    check_raw("R2 high level gone", 32'h0);
  endtask

  task automatic t_undef();
    wreg(8'h14, 32'hA0);
    pin(5, 1'b1); pin(7, 1'b1); cyc(4);
    pin(5, 1'b0); pin(7, 1'b0); cyc(4);
    check_raw("R8 undefined codes", 32'h0);
  endtask

  task automatic t_allow();
    logic [31:0] v;
    wreg(8'h14, 32'h0);
    rreg(8'h14, v); check("R3 allow readback", v, 32'h0);
    pin(6, 1'b1); cyc(4); check_raw("R3 disallowed edge", 32'h0);
    wreg(8'h14, 32'h40); cyc(3); check_raw("R3 stale edge dropped", 32'h0);
    pin(6, 1'b0); cyc(4); pin(6, 1'b1); cyc(4);
    check_raw("R3 allowed edge", 32'h40);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wreg(8'h1C, 32'h40);
    rreg(8'h18, v); check("R4 disable one bit", v, 32'hFFFF_FFBF);
    rreg(8'h24, v); check("R4 masked status", v, 32'h0);
    check("R4 irq masked", {31'd0, irq_lo}, 32'h0);
    check_raw("R5 raw unmasked", 32'h40);
    wreg(8'h18, 32'h40);
    rreg(8'h24, v); check("R4 re-enabled", v, 32'h40);
    check("R7 irq lo back", {31'd0, irq_lo}, 32'h1);
    wreg(8'h14, 32'h0);
    rreg(8'h24, v); check("R5 allow gates status", v, 32'h0);
    wreg(8'h28, 32'hFFFF_FFFF);
    check_raw("R6 ack all", 32'h0);
  endtask

  task automatic t_hi();
    logic [31:0] v;
    wreg(8'h14, 32'h0010_0000);
    pin(20, 1'b1); cyc(4);
    rreg(8'h24, v); check("R7 pin20 status", v, 32'h0010_0000);
    check("R7 hi only", {30'd0, irq_hi, irq_lo}, 32'h2);
    wreg(8'h28, 32'h0010_0000);
    check("R7 hi cleared", {31'd0, irq_hi}, 32'h0);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_setup();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_undef();
    t_allow();
    t_mask();
    t_hi();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule